// File: doc/BRIEF.md
# Iterative Multi-Mode Shift Unit

This block performs 32-bit shifts for a load/store register machine without a combinational barrel shifter. An accepted start pulse latches the operand into a working register, selects a shift count and then moves the working value by one bit position per clock cycle while a down-counter runs to zero. When the counter empties, a single-cycle done pulse marks the result as final.

Four modes are selected by a 5-bit opcode: logical right, arithmetic right, logical left and circular (rotate) left. The shift count is taken from a 5-bit immediate field when that field is nonzero. When the immediate is zero, the count comes from the low five bits of a count register. The result stays on the output until the next accepted start. The register file, instruction fetch and bus transfers sit around this unit and are not part of it.

Top module: `iter_shift_unit`

## Requirements
- R1: After reset `done_o` is 0 and `result_o` is 0.
- R2: The shift count is `imm_cnt_i` when that value is nonzero. Otherwise it is `reg_cnt_i`, and both are sampled in the start cycle.
- R3: For a nonzero count n, `done_o` is high exactly in the cycle that follows the n-th rising edge after the start edge. It lasts one cycle.
- R4: Opcode 26 (logical right) shifts toward bit 0 and fills bit 31 with 0 on each step.
- R5: Opcode 27 (arithmetic right) shifts toward bit 0 and copies the old bit 31 into bit 31 on each step.
- R6: Opcode 28 (logical left) shifts toward bit 31 and fills bit 0 with 0 on each step.
- R7: Opcode 29 (circular left) shifts toward bit 31 and moves the old bit 31 into bit 0 on each step.
- R8: If the selected count is zero, `done_o` is high in the cycle right after the start edge, and `result_o` equals the operand unchanged.
- R9: A start that arrives while a shift is in progress is ignored. The running operation finishes at its original time with its original result.
- R10: A start whose opcode is not in 26..29 is ignored. No done pulse follows, and `result_o` keeps its value.
- R11: After the done pulse, `result_o` holds its value until the next accepted start.
- R12: A start presented in the same cycle as a done pulse is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request for one cycle |
| opcode_i | input | 5 | Shift opcode (26..29) |
| operand_i | input | 32 | Value to shift |
| imm_cnt_i | input | 5 | Immediate shift count field |
| reg_cnt_i | input | 5 | Low bits of the count register |
| result_o | output | 32 | Shifted value; final when done pulses |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Two things can fall in the same cycle: the completion of one shift and the arrival of the next start. The bench provokes this in two ways. First, it drives a new start in exactly the cycle where it sees the done pulse; the unit must accept it and deliver the second result after that operation's own count. Second, it pulses start part-way through a long shift; the pulse must be discarded, with the first operation's done timing and value unchanged and no extra done pulse afterwards. Both cases are judged at the ports by counting cycles from the start edge to the done pulse and by comparing the result against a bit-step model of the mode.

// File: rtl/iter_shift_pkg.sv
package iter_shift_pkg;
  localparam int unsigned OP_W = 5;

  typedef enum logic [1:0] {
    MODE_LSR = 2'd0,
    MODE_ASR = 2'd1,
    MODE_LSL = 2'd2,
    MODE_ROL = 2'd3
  } shift_mode_e;

  localparam logic [OP_W-1:0] OPC_LSR = 5'd26;
  localparam logic [OP_W-1:0] OPC_ASR = 5'd27;
  localparam logic [OP_W-1:0] OPC_LSL = 5'd28;
  localparam logic [OP_W-1:0] OPC_ROL = 5'd29;
endpackage

// File: rtl/shift_decode.sv
module shift_decode
  import iter_shift_pkg::*;
(
  input  logic [OP_W-1:0] opcode_i,
  output logic            valid_o,
  output shift_mode_e     mode_o
);
  always_comb begin
    valid_o = 1'b1;
    mode_o  = MODE_LSR;
    unique case (opcode_i)
      OPC_LSR: mode_o = MODE_LSR;
      OPC_ASR: mode_o = MODE_ASR;
      OPC_LSL: mode_o = MODE_LSL;
      OPC_ROL: mode_o = MODE_ROL;
      default: valid_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/shift_count_sel.sv
module shift_count_sel #(
  parameter int unsigned CNT_W = 5
) (
  input  logic [CNT_W-1:0] imm_cnt_i,
  input  logic [CNT_W-1:0] reg_cnt_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);
  // immediate wins unless it is zero
  assign cnt_o  = (imm_cnt_i != '0) ? imm_cnt_i : reg_cnt_i;
  assign zero_o = (cnt_o == '0);
endmodule

// File: rtl/shift_step.sv
module shift_step
  import iter_shift_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  shift_mode_e       mode_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    logic nb;
    if (i == DATA_W-1) begin : g_msb
      always_comb begin
        unique case (mode_i)
          MODE_LSR: nb = 1'b0;
          MODE_ASR: nb = data_i[i];
          default:  nb = data_i[i-1];
        endcase
      end
    end else if (i == 0) begin : g_lsb
      always_comb begin
        unique case (mode_i)
          MODE_LSL: nb = 1'b0;
          MODE_ROL: nb = data_i[DATA_W-1];
          default:  nb = data_i[i+1];
        endcase
      end
    end else begin : g_mid
      always_comb begin
        unique case (mode_i)
          MODE_LSR, MODE_ASR: nb = data_i[i+1];
          default:            nb = data_i[i-1];
        endcase
      end
    end
    assign data_o[i] = nb;
  end
endmodule

// File: rtl/shift_ctrl.sv
module shift_ctrl #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             valid_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cnt_zero_i,
  output logic             load_o,
  output logic             step_o,
  output logic             busy_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] CntOne = CNT_W'(1);

  logic             busy_q, done_q;
  logic [CNT_W-1:0] cnt_q;

  assign load_o = start_i && valid_i && !busy_q;
  assign step_o = busy_q;
  assign busy_o = busy_q;
  assign cnt_o  = cnt_q;
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else if (load_o) begin
      busy_q <= !cnt_zero_i;
      done_q <= cnt_zero_i;
      cnt_q  <= cnt_i;
    end else if (busy_q) begin
      // busy implies cnt_q >= 1
      cnt_q  <= cnt_q - CntOne;
      busy_q <= (cnt_q != CntOne);
      done_q <= (cnt_q == CntOne);
    end else begin
      done_q <= 1'b0;
    end
  end
endmodule

// File: rtl/iter_shift_unit.sv
module iter_shift_unit
  import iter_shift_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [OP_W-1:0]   opcode_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic [CNT_W-1:0]  imm_cnt_i,
  input  logic [CNT_W-1:0]  reg_cnt_i,
  output logic [DATA_W-1:0] result_o,
  output logic              done_o
);
  logic              op_valid, cnt_zero, load, step, busy_q;
  shift_mode_e       dec_mode, mode_q;
  logic [CNT_W-1:0]  sel_cnt, cnt_q;
  logic [DATA_W-1:0] c_q, c_next;

  shift_decode u_dec (
    .opcode_i (opcode_i),
    .valid_o  (op_valid),
    .mode_o   (dec_mode)
  );

  shift_count_sel #(.CNT_W(CNT_W)) u_cnt (
    .imm_cnt_i (imm_cnt_i),
    .reg_cnt_i (reg_cnt_i),
    .cnt_o     (sel_cnt),
    .zero_o    (cnt_zero)
  );

  shift_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .valid_i    (op_valid),
    .cnt_i      (sel_cnt),
    .cnt_zero_i (cnt_zero),
    .load_o     (load),
    .step_o     (step),
    .busy_o     (busy_q),
    .cnt_o      (cnt_q),
    .done_o     (done_o)
  );

  shift_step #(.DATA_W(DATA_W)) u_step (
    .mode_i (mode_q),
    .data_i (c_q),
    .data_o (c_next)
  );

  // working register doubles as the result holder
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c_q    <= '0;
      mode_q <= MODE_LSR;
    end else if (load) begin
      c_q    <= operand_i;
      mode_q <= dec_mode;
    end else if (step) begin
      c_q <= c_next;
    end
  end

  assign result_o = c_q;
endmodule

// File: rtl/iter_shift_checker.sv
module iter_shift_checker
  import iter_shift_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [OP_W-1:0]   opcode_i,
  input logic [DATA_W-1:0] operand_i,
  input logic [CNT_W-1:0]  imm_cnt_i,
  input logic [CNT_W-1:0]  reg_cnt_i,
  input logic [DATA_W-1:0] result_o,
  input logic              done_o,
  input logic              busy_q,
  input logic [CNT_W-1:0]  cnt_q,
  input shift_mode_e       mode_q
);
  logic op_ok, accept;
  assign op_ok  = (opcode_i >= OPC_LSR) && (opcode_i <= OPC_ROL);
  assign accept = start_i && !busy_q && op_ok;

  assert_imm_count_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && (imm_cnt_i != '0) |=> busy_q && (cnt_q == $past(imm_cnt_i)));

  assert_reg_count_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && (imm_cnt_i == '0) && (reg_cnt_i != '0) |=> busy_q && (cnt_q == $past(reg_cnt_i)));

  assert_last_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && (cnt_q == CNT_W'(1)) |=> done_o && !busy_q);

  assert_done_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_q);

  assert_lsr_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && (mode_q == MODE_LSR) |=> result_o == {1'b0, $past(result_o[DATA_W-1:1])});

  assert_asr_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && (mode_q == MODE_ASR) |=>
      result_o == {$past(result_o[DATA_W-1]), $past(result_o[DATA_W-1:1])});

  assert_lsl_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && (mode_q == MODE_LSL) |=> result_o == {$past(result_o[DATA_W-2:0]), 1'b0});

  assert_rol_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && (mode_q == MODE_ROL) |=>
      result_o == {$past(result_o[DATA_W-2:0]), $past(result_o[DATA_W-1])});

  assert_zero_count_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && (imm_cnt_i == '0) && (reg_cnt_i == '0) |=> done_o && (result_o == $past(operand_i)));

  assert_busy_ignore_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && (cnt_q > CNT_W'(1)) |=> busy_q && (cnt_q == $past(cnt_q) - CNT_W'(1)));

  assert_bad_op_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_q && !op_ok |=> !done_o && !busy_q);

  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q && !accept |=> $stable(result_o));
endmodule

bind iter_shift_unit iter_shift_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .opcode_i  (opcode_i),
  .operand_i (operand_i),
  .imm_cnt_i (imm_cnt_i),
  .reg_cnt_i (reg_cnt_i),
  .result_o  (result_o),
  .done_o    (done_o),
  .busy_q    (busy_q),
  .cnt_q     (cnt_q),
  .mode_q    (mode_q)
);

// File: tb/iter_shift_unit_bench.sv
`timescale 1ns/1ps
module iter_shift_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  opcode = '0;
  logic [31:0] operand = '0;
  logic [4:0]  imm_cnt = '0;
  logic [4:0]  reg_cnt = '0;
  logic [31:0] result;
  logic        done;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  iter_shift_unit u_iter_shift_unit (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .start_i   (start),
    .opcode_i  (opcode),
    .operand_i (operand),
    .imm_cnt_i (imm_cnt),
    .reg_cnt_i (reg_cnt),
    .result_o  (result),
    .done_o    (done)
  );

  function automatic logic [31:0] model(logic [4:0] op, logic [31:0] x, int n);
    for (int i = 0; i < n; i++) begin
      case (op)
        5'd26: x = {1'b0, x[31:1]};
        5'd27: x = {x[31], x[31:1]};
        5'd28: x = {x[30:0], 1'b0};
        5'd29: x = {x[30:0], x[31]};
        default: ;
      endcase
    end
    return x;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // called just after a negedge; returns just after the negedge following the start edge
  task automatic issue(logic [4:0] op, logic [31:0] x, logic [4:0] imm, logic [4:0] rc);
    start = 1'b1; opcode = op; operand = x; imm_cnt = imm; reg_cnt = rc;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic expect_done(int n, logic [31:0] res, string req, bit pulse_chk);
    int idx = 0;
    while (!done && idx < 40) begin
      @(negedge clk);
      idx++;
    end
    check(idx == n, {req, " latency"}, 32'(idx), 32'(n));
    check(result == res, {req, " result"}, result, res);
    if (pulse_chk) begin
      @(negedge clk);
      check(!done, {req, " R3 single pulse"}, 32'(done), 32'd0);
    end
  endtask

  task automatic t_reset();
    check(done == 1'b0, "R1 done", 32'(done), 32'd0);
    check(result == 32'd0, "R1 result", result, 32'd0);
  endtask

  task automatic t_modes();
    logic [31:0] pats [3] = '{32'h8000_0001, 32'h1234_5678, 32'hF0F0_0F0F};
    int cnts [3] = '{1, 7, 31};
    for (int m = 0; m < 4; m++) begin
      for (int p = 0; p < 3; p++) begin
        logic [4:0] op = 5'(26 + m);
        string tag;
        case (m)
          0: tag = "R4 lsr";
          1: tag = "R5 asr";
          2: tag = "R6 lsl";
          default: tag = "R7 rol";
        endcase
        issue(op, pats[p], 5'(cnts[p]), 5'd3);
        expect_done(cnts[p], model(op, pats[p], cnts[p]), {tag, " R3"}, 1'b1);
      end
    end
  endtask

  task automatic t_count_sel();
    issue(5'd28, 32'h0000_00FF, 5'd0, 5'd5);
    expect_done(5, model(5'd28, 32'h0000_00FF, 5), "R2 reg count", 1'b1);
    issue(5'd26, 32'hFF00_0000, 5'd3, 5'd9);
    expect_done(3, model(5'd26, 32'hFF00_0000, 3), "R2 imm count", 1'b1);
  endtask

  task automatic t_zero();
    issue(5'd27, 32'hDEAD_BEEF, 5'd0, 5'd0);
    expect_done(0, 32'hDEAD_BEEF, "R8 zero count", 1'b1);
  endtask

  task automatic t_busy_start();
    issue(5'd29, 32'hA5A5_0001, 5'd10, 5'd0);
    repeat (3) @(negedge clk);
    issue(5'd26, 32'h1111_1111, 5'd1, 5'd0);
    expect_done(6, model(5'd29, 32'hA5A5_0001, 10), "R9 start while busy", 1'b1);
    repeat (4) begin
      @(negedge clk);
      check(!done, "R9 no extra done", 32'(done), 32'd0);
    end
  endtask

  task automatic t_bad_op_hold();
    logic [31:0] held = result;
    issue(5'd12, 32'h5555_AAAA, 5'd2, 5'd0);
    for (int i = 0; i < 40; i++) begin
      if (done) break;
      @(negedge clk);
    end
    check(!done, "R10 no done", 32'(done), 32'd0);
    check(result == held, "R10 R11 result held", result, held);
  endtask

  task automatic t_back2back();
    issue(5'd28, 32'h0000_0003, 5'd2, 5'd0);
    expect_done(2, 32'h0000_000C, "R12 first", 1'b0);
    issue(5'd27, 32'h8000_0000, 5'd3, 5'd0);
    expect_done(3, 32'hF000_0000, "R12 second", 1'b1);
    repeat (5) @(negedge clk);
    check(result == 32'hF000_0000, "R11 hold after done", result, 32'hF000_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_modes();
    t_count_sel();
    t_zero();
    t_busy_start();
    t_bad_op_hold();
    t_back2back();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule